// File: doc/BRIEF.md
# Multi-Channel Clock-Enable Prescaler

This block sits between two clock sources and a group of peripheral channels. The sources arrive as single-cycle strobes in the system clock domain: a fast strobe from the main or PLL-derived clock and a slow strobe from a low-frequency clock of about 32 kHz. A register bit selects which strobe advances one shared 12-bit binary counter. Each channel taps that counter at a ratio it chooses, from 1 to 4096 in powers of two. Each channel emits a one-cycle clock-enable pulse at that rate. The block never gates a clock.

A global run bit can freeze the counter and silence every channel when no consumer needs a time base. Clearing the bit holds the counter at its value, and setting it again resumes counting from that value. Each channel also has its own enable bit, so an idle peripheral can be cut off while the others keep ticking from the same chain.

Top module: `clk_prescaler_gate`

## Requirements
- R1: After reset the source select is 0 (fast strobe), the run bit is 1, every channel field reads 0 (ratio code 0, disabled) and every channel output is low.
- R2: With source select 0 only `fast_stb` advances the counter and `slow_stb` is ignored. With source select 1 only `slow_stb` advances it and `fast_stb` is ignored.
- R3: A channel with ratio code k (0 to 12) pulses on every advancing strobe whose 1-based count since reset is a multiple of 2^k. Code 0 passes every advancing strobe through.
- R4: Ratio codes 13 to 15 behave as code 12 (divide by 4096).
- R5: A channel whose enable bit is 0 holds its output low whatever the counter does.
- R6: While the run bit is 0 no strobe advances the counter and no channel pulses. After the bit is set to 1 again, counting resumes from the held value.
- R7: A channel pulse is high for exactly the one cycle that follows the advancing strobe which produced it.
- R8: Register map: address 0 bit 0 is source select. Address 1 bit 5 is the run bit. Address 2+c is channel c, with bits 3:0 as the ratio code and bit 7 as the enable. Every field reads back through `reg_rdata` and all other bits read 0.
- R9: Channels tap the shared counter independently, so different ratios on different channels hold at the same time.
- R10: A change of ratio takes effect at the next advancing strobe, with no lost or doubled pulse at the new ratio's multiples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_stb | input | 1 | One-cycle strobe of the high-speed source |
| slow_stb | input | 1 | One-cycle strobe of the low-speed source |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| ch_en | output | NCH | Per-channel clock-enable pulses |

## Verification
A register write is visible on `reg_rdata` one clock after the write edge. A channel pulse appears in the cycle after the edge that samples its advancing strobe. The bench drives inputs just after a rising edge and samples at the falling edge. It counts pulses over a window that extends two cycles past the last strobe, so the pulse from the final strobe is always included. The single-cycle timing check samples the pulse at the first falling edge after the strobe's edge and checks that it is gone one cycle later.

// File: rtl/clk_prescaler_gate.sv
module clk_prescaler_gate #(
  parameter int NCH = 4,
  parameter int CW  = 12,
  parameter int AW  = $clog2(NCH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fast_stb,
  input  logic           slow_stb,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic [NCH-1:0] ch_en
);

  localparam int RUN_BIT = 5;

  logic           src_sel, run;
  logic [CW-1:0]  cnt;
  logic [CW:0]    carry;
  logic [3:0]     ratio [NCH];
  logic [NCH-1:0] gate;
  logic           src_stb, adv;

  assign src_stb = src_sel ? slow_stb : fast_stb;
  assign adv     = run & src_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel <= 1'b0;
      run     <= 1'b1;
    end else if (reg_we) begin
      if (reg_addr == AW'(0)) src_sel <= reg_wdata[0];
      if (reg_addr == AW'(1)) run     <= reg_wdata[RUN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  assign carry[0] = 1'b1;
  for (genvar i = 0; i < CW; i++) begin : g_carry
    assign carry[i+1] = carry[i] & cnt[i];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [3:0] code;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ratio[c] <= '0;
        gate[c]  <= 1'b0;
      end else if (reg_we && reg_addr == AW'(c + 2)) begin
        ratio[c] <= reg_wdata[3:0];
        gate[c]  <= reg_wdata[7];
      end
    end

    assign code = (ratio[c] > 4'(CW)) ? 4'(CW) : ratio[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_en[c] <= 1'b0;
      else        ch_en[c] <= adv & gate[c] & carry[code];
    end

    assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !gate[c] |=> !ch_en[c]);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(0))      reg_rdata[0]       = src_sel;
    else if (reg_addr == AW'(1)) reg_rdata[RUN_BIT] = run;
    else begin
      for (int c = 0; c < NCH; c++)
        if (reg_addr == AW'(c + 2)) reg_rdata = {gate[c], 3'b000, ratio[c]};
    end
  end

  assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ch_en == '0);
  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> cnt == $past(cnt) + 1'b1);
  assert_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !src_stb |=> ch_en == '0);

endmodule

// File: tb/clk_prescaler_gate_tb.sv
module clk_prescaler_gate_tb;
  localparam int NCH = 4;
  localparam int AW  = $clog2(NCH + 2);

  logic clk = 0, rst_n = 0, fast_stb = 0, slow_stb = 0, reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] ch_en;

  int n_chk = 0, n_fail = 0;
  int pulses [NCH];
  bit counting = 0;

  always #2 clk = ~clk;

  clk_prescaler_gate #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fast_stb(fast_stb), .slow_stb(slow_stb),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ch_en(ch_en));

  always @(negedge clk)
    if (counting)
      for (int c = 0; c < NCH; c++) if (ch_en[c]) pulses[c]++;

  localparam int NV = 10;
  localparam int V_CODE [NV] = '{0, 1, 2, 3, 5, 12, 12, 11, 15, 13};
  localparam int V_EN   [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 1, 1};
  localparam int V_N    [NV] = '{20, 20, 20, 40, 100, 4096, 4095, 4096, 4096, 4095};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = AW'(a); reg_wdata = 8'(d);
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = AW'(a);
    #0.5 d = reg_rdata;
  endtask

  task automatic strobes(input int n, input bit f, input bit s);
    for (int c = 0; c < NCH; c++) pulses[c] = 0;
    counting = 1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      fast_stb = f; slow_stb = s;
    end
    @(posedge clk); #1;
    fast_stb = 0; slow_stb = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    counting = 0;
  endtask

  function automatic int expect_cnt(int code, int en, int n);
    int k = (code > 12) ? 12 : code;
    return en ? (n >> k) : 0;
  endfunction

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int d, code;
    do_reset();

    // R1 / R8 reset state and register layout
    @(negedge clk);
    check("R1 outputs", int'(ch_en), 0);
    rd(0, d); check("R1 select", d, 0);
    rd(1, d); check("R1 run", d, 8'h20);
    for (int c = 0; c < NCH; c++) begin
      rd(c + 2, d); check("R1 channel field", d, 0);
    end

    // R3 R4 R5 vector table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr(2, (V_EN[v] << 7) | V_CODE[v]);
      strobes(V_N[v], 1, 0);
      check($sformatf("R3/R4/R5 vec%0d", v), pulses[0],
            expect_cnt(V_CODE[v], V_EN[v], V_N[v]));
    end

    // R8 readback
    do_reset();
    wr(2, 8'h8B); rd(2, d); check("R8 ch0 readback", d, 8'h8B);
    wr(5, 8'h8F); rd(5, d); check("R8 ch3 readback", d, 8'h8F);
    wr(0, 8'hFF); rd(0, d); check("R8 select readback", d, 1);
    wr(1, 8'h00); rd(1, d); check("R8 run readback", d, 0);

    // R2 source selection
    do_reset();
    wr(2, 8'h80);
    strobes(10, 0, 1); check("R2 slow ignored sel0", pulses[0], 0);
    strobes(10, 1, 0); check("R2 fast counted sel0", pulses[0], 10);
    wr(0, 1);
    strobes(10, 1, 0); check("R2 fast ignored sel1", pulses[0], 0);
    strobes(10, 0, 1); check("R2 slow counted sel1", pulses[0], 10);

    // R6 stop holds counter, resume continues
    do_reset();
    wr(2, 8'h84);
    strobes(10, 1, 0); check("R6 before stop", pulses[0], 0);
    wr(1, 0);
    strobes(20, 1, 0); check("R6 silent while stopped", pulses[0], 0);
    wr(1, 8'h20);
    strobes(6, 1, 0);  check("R6 resume from held", pulses[0], 1);

    // R7 single-cycle pulse timing
    do_reset();
    wr(2, 8'h80);
    @(posedge clk); #1 fast_stb = 1;
    @(posedge clk); #1 fast_stb = 0;
    @(negedge clk); check("R7 pulse next cycle", int'(ch_en[0]), 1);
    @(negedge clk); check("R7 pulse one cycle", int'(ch_en[0]), 0);

    // R9 independent channels
    do_reset();
    wr(2, 8'h81); wr(3, 8'h83); wr(4, 8'h06); wr(5, 8'h80);
    strobes(64, 1, 0);
    check("R9 ch0 div2", pulses[0], 32);
    check("R9 ch1 div8", pulses[1], 8);
    check("R9 ch2 disabled", pulses[2], 0);
    check("R9 ch3 div1", pulses[3], 64);

    // R10 ratio change mid-stream
    do_reset();
    wr(2, 8'h81);
    strobes(3, 1, 0); check("R10 before change", pulses[0], 1);
    wr(2, 8'h82);
    strobes(5, 1, 0); check("R10 after change", pulses[0], 2);

    code = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule